// File: doc/BRIEF.md
# Garbage Collection Victim Selector

This block reclaims one flash erase block per request without any processor help. It keeps metadata for every block: a valid-page bitmap, a programmed-page bitmap, a stale-page count and an erase count. A host-side metadata port records page programs and page invalidations. Physical pages are never rewritten in place, so a newer copy of a logical page lands elsewhere and the old copy is invalidated. When started, the engine scores every block once, one block per cycle. The score is `stale_count * W_STALE - erase_count * W_ERASE`. The engine picks the best block as the victim and copies each still-valid page into the current spare block. For each copy it emits a relocation record of the old and new physical page. It then erases the victim, which becomes the new spare block.

Flash traffic goes through three command ports toward a flash model: page read, page write and block erase. Read data returns on a response strobe, and erase completion on a done strobe. The read, write, erase and relocation-record ports are valid/ready. Once raised, a valid stays high and its payload stays unchanged until the cycle in which ready is high. The transfer happens in that cycle. The engine never has more than one command valid at a time, so back-pressure on any port simply stalls the whole sequence. Read responses arriving while no read is outstanding are ignored.

A physical page address is `block * PPB + page`. Blocks are numbered 0 to NBLK-1 and pages 0 to PPB-1.

Top module: `gc_reclaim_engine`

## Requirements
- R1: After reset, busy and done are low, every block has an empty valid bitmap, stale count 0 and erase count 0, and the spare block is NBLK-1.
- R2: When idle, a metadata op with meta_op=0 (program) marks a never-programmed page valid. Programming an already programmed page has no effect. meta_op=1 (invalidate) on a valid page clears it and adds one to the block's stale count; on a non-valid page it has no effect. Ops aimed at the spare block, and all ops while busy, are ignored.
- R3: The victim is the eligible block with the highest score `stale*W_STALE - erase*W_ERASE`; on equal scores the lower block index wins.
- R4: A block is ineligible if it is the spare block, has stale count 0, or has erase count at or above erase_target. With no eligible block, done pulses with found low and no flash command is issued.
- R5: The scan takes one cycle per block: with no victim, done is high in the NBLK+1-th cycle after the start cycle. With a victim whose first valid page is f, the first read request is valid in the cycle NBLK+2+f after the start cycle.
- R6: Valid pages of the victim are relocated in ascending page order. For each one: read the old page, write the returned data to the next free page of the spare block (starting at page 0), then present the record (old, new). Only one command port is valid at a time.
- R7: A raised read, write, record or erase valid holds, with unchanged payload, until accepted.
- R8: The erase of the victim is issued only after all its records are accepted. done pulses in the cycle after erase-done is seen. The victim then has erase count +1, stale count 0 and no valid pages, it becomes the spare block, and the copied pages are valid in the old spare block.
- R9: busy rises the cycle after start when idle and stays high until done. done lasts one cycle. A start while busy is ignored and causes no second run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one reclaim when idle |
| erase_target | input | ECW | Erase count at which a block is excluded |
| busy | output | 1 | Reclaim in progress |
| done | output | 1 | One-cycle end-of-reclaim pulse |
| found | output | 1 | With done: a victim was reclaimed |
| victim | output | BW | With done: index of the reclaimed block |
| meta_vld | input | 1 | Metadata op strobe |
| meta_op | input | 1 | 0 program, 1 invalidate |
| meta_blk | input | BW | Block of the op |
| meta_page | input | PW | Page of the op |
| mon_blk | input | BW | Block selected for the metadata view |
| mon_valid | output | PPB | Valid bitmap of mon_blk |
| mon_stale | output | STW | Stale count of mon_blk |
| mon_erase | output | ECW | Erase count of mon_blk |
| spare_blk | output | BW | Current spare block |
| rd_vld | output | 1 | Page read request valid |
| rd_rdy | input | 1 | Page read request ready |
| rd_addr | output | AW | Physical page to read |
| rsp_vld | input | 1 | Read data strobe |
| rsp_data | input | DW | Read data |
| wr_vld | output | 1 | Page write request valid |
| wr_rdy | input | 1 | Page write request ready |
| wr_addr | output | AW | Physical page to write |
| wr_data | output | DW | Data to write |
| rec_vld | output | 1 | Relocation record valid |
| rec_rdy | input | 1 | Relocation record ready |
| rec_old | output | AW | Page the data left |
| rec_new | output | AW | Page the data moved to |
| er_vld | output | 1 | Erase request valid |
| er_rdy | input | 1 | Erase request ready |
| er_blk | output | BW | Block to erase |
| er_done | input | 1 | Erase completion strobe |

## Verification
The done pulse for a run with no victim is due exactly NBLK+1 cycles after the start cycle. The first read of a run with a victim is due NBLK+2+f cycles after start, where f is the first valid page. The done of a run with a victim is due one cycle after erase-done. The bench counts cycles from its own start drive and checks these instants on the falling edge. Each handshake is checked in the cycle it is accepted against a victim and page list predicted by a behavioural model at start. The metadata view is compared with the model on every idle cycle, so an op or start that should be ignored shows up on the next comparison.

// File: rtl/gcv_pkg.sv
package gcv_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SCAN, S_PAGE, S_RD, S_RDW, S_WR, S_REC, S_ERASE, S_EWAIT, S_FIN
  } gc_state_e;
endpackage

// File: rtl/gcv_meta_store.sv
module gcv_meta_store #(
  parameter int NBLK = 8,
  parameter int PPB  = 8,
  parameter int ECW  = 12,
  localparam int BW  = $clog2(NBLK),
  localparam int PW  = $clog2(PPB),
  localparam int STW = $clog2(PPB + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_we,
  input  logic           host_inval,
  input  logic [BW-1:0]  host_blk,
  input  logic [PW-1:0]  host_page,
  input  logic           rel_we,
  input  logic [BW-1:0]  rel_blk,
  input  logic [PW-1:0]  rel_page,
  input  logic           cmt_we,
  input  logic [BW-1:0]  cmt_blk,
  input  logic [BW-1:0]  scan_blk,
  output logic [PPB-1:0] scan_valid,
  output logic [STW-1:0] scan_stale,
  output logic [ECW-1:0] scan_ecnt,
  input  logic [BW-1:0]  mon_blk,
  output logic [PPB-1:0] mon_valid,
  output logic [STW-1:0] mon_stale,
  output logic [ECW-1:0] mon_ecnt
);
  logic [PPB-1:0] valid_a [NBLK];
  logic [STW-1:0] stale_a [NBLK];
  logic [ECW-1:0] ecnt_a  [NBLK];

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic [PPB-1:0] v_q, p_q;
    logic [STW-1:0] s_q;
    logic [ECW-1:0] e_q;
    wire hit_cmt  = cmt_we  && (cmt_blk  == BW'(b));
    wire hit_rel  = rel_we  && (rel_blk  == BW'(b));
    wire hit_host = host_we && (host_blk == BW'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= '0;
        p_q <= '0;
        s_q <= '0;
        e_q <= '0;
      end else if (hit_cmt) begin
        v_q <= '0;
        p_q <= '0;
        s_q <= '0;
        e_q <= e_q + 1'b1;
      end else begin
        if (hit_rel) begin
          v_q[rel_page] <= 1'b1;
          p_q[rel_page] <= 1'b1;
        end
        if (hit_host) begin
          if (!host_inval) begin
            if (!p_q[host_page]) begin
              v_q[host_page] <= 1'b1;
              p_q[host_page] <= 1'b1;
            end
          end else if (v_q[host_page]) begin
            v_q[host_page] <= 1'b0;
            s_q <= s_q + 1'b1;
          end
        end
      end
    end

    assign valid_a[b] = v_q;
    assign stale_a[b] = s_q;
    assign ecnt_a[b]  = e_q;
  end

  assign scan_valid = valid_a[scan_blk];
  assign scan_stale = stale_a[scan_blk];
  assign scan_ecnt  = ecnt_a[scan_blk];
  assign mon_valid  = valid_a[mon_blk];
  assign mon_stale  = stale_a[mon_blk];
  assign mon_ecnt   = ecnt_a[mon_blk];
endmodule

// File: rtl/gcv_scorer.sv
module gcv_scorer #(
  parameter int NBLK    = 8,
  parameter int PPB     = 8,
  parameter int ECW     = 12,
  parameter int W_STALE = 2,
  parameter int W_ERASE = 3,
  parameter int SW      = 24,
  localparam int BW     = $clog2(NBLK),
  localparam int STW    = $clog2(PPB + 1)
) (
  input  logic [BW-1:0]        blk,
  input  logic [BW-1:0]        spare,
  input  logic [STW-1:0]       stale,
  input  logic [ECW-1:0]       ecnt,
  input  logic [ECW-1:0]       target,
  output logic                 elig,
  output logic signed [SW-1:0] score
);
  logic [SW-1:0] gain, cost;

  always_comb begin
    gain  = SW'(stale) * SW'(W_STALE);
    cost  = SW'(ecnt) * SW'(W_ERASE);
    score = $signed(gain - cost);
    elig  = (blk != spare) && (stale != '0) && (ecnt < target);
  end
endmodule

// File: rtl/gcv_seq.sv
module gcv_seq
  import gcv_pkg::*;
#(
  parameter int NBLK = 8,
  parameter int PPB  = 8,
  parameter int DW   = 16,
  parameter int SW   = 24,
  localparam int BW  = $clog2(NBLK),
  localparam int PW  = $clog2(PPB),
  localparam int AW  = $clog2(NBLK * PPB)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic                 found,
  output logic [BW-1:0]        victim,
  output logic [BW-1:0]        spare,
  output logic [BW-1:0]        scan_blk,
  input  logic [PPB-1:0]       scan_valid,
  input  logic                 elig,
  input  logic signed [SW-1:0] score,
  output logic                 rd_vld,
  input  logic                 rd_rdy,
  output logic [AW-1:0]        rd_addr,
  input  logic                 rsp_vld,
  input  logic [DW-1:0]        rsp_data,
  output logic                 wr_vld,
  input  logic                 wr_rdy,
  output logic [AW-1:0]        wr_addr,
  output logic [DW-1:0]        wr_data,
  output logic                 rec_vld,
  input  logic                 rec_rdy,
  output logic [AW-1:0]        rec_old,
  output logic [AW-1:0]        rec_new,
  output logic                 er_vld,
  input  logic                 er_rdy,
  output logic [BW-1:0]        er_blk,
  input  logic                 er_done,
  output logic                 rel_we,
  output logic [BW-1:0]        rel_blk,
  output logic [PW-1:0]        rel_page,
  output logic                 cmt_we,
  output logic [BW-1:0]        cmt_blk
);
  gc_state_e            state;
  logic [BW-1:0]        idx, best;
  logic signed [SW-1:0] best_score;
  logic                 found_q;
  logic [PW-1:0]        page, wptr;
  logic [BW-1:0]        spare_q;
  logic [DW-1:0]        data_q;

  wire last_page = (page == PW'(PPB - 1));
  wire take      = elig && (!found_q || (score > best_score));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      idx        <= '0;
      best       <= '0;
      best_score <= '0;
      found_q    <= 1'b0;
      page       <= '0;
      wptr       <= '0;
      spare_q    <= BW'(NBLK - 1);
      data_q     <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_SCAN;
          idx     <= '0;
          found_q <= 1'b0;
        end
        S_SCAN: begin
          if (take) begin
            best       <= idx;
            best_score <= score;
            found_q    <= 1'b1;
          end
          if (idx == BW'(NBLK - 1)) begin
            state <= (found_q || elig) ? S_PAGE : S_FIN;
            page  <= '0;
            wptr  <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_PAGE: begin
          if (scan_valid[page]) state <= S_RD;
          else if (last_page)   state <= S_ERASE;
          else                  page  <= page + 1'b1;
        end
        S_RD: if (rd_rdy) state <= S_RDW;
        S_RDW: if (rsp_vld) begin
          data_q <= rsp_data;
          state  <= S_WR;
        end
        S_WR: if (wr_rdy) state <= S_REC;
        S_REC: if (rec_rdy) begin
          wptr <= wptr + 1'b1;
          if (last_page) state <= S_ERASE;
          else begin
            page  <= page + 1'b1;
            state <= S_PAGE;
          end
        end
        S_ERASE: if (er_rdy) state <= S_EWAIT;
        S_EWAIT: if (er_done) begin
          spare_q <= best;
          state   <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy     = (state != S_IDLE);
    done     = (state == S_FIN);
    found    = found_q;
    victim   = best;
    spare    = spare_q;
    scan_blk = (state == S_SCAN) ? idx : best;
    rd_vld   = (state == S_RD);
    wr_vld   = (state == S_WR);
    rec_vld  = (state == S_REC);
    er_vld   = (state == S_ERASE);
    rd_addr  = AW'(best) * AW'(PPB) + AW'(page);
    wr_addr  = AW'(spare_q) * AW'(PPB) + AW'(wptr);
    wr_data  = data_q;
    rec_old  = rd_addr;
    rec_new  = wr_addr;
    er_blk   = best;
    rel_we   = (state == S_REC) && rec_rdy;
    rel_blk  = spare_q;
    rel_page = wptr;
    cmt_we   = (state == S_EWAIT) && er_done;
    cmt_blk  = best;
  end
endmodule

// File: rtl/gc_reclaim_engine.sv
module gc_reclaim_engine #(
  parameter int NBLK    = 8,
  parameter int PPB     = 8,
  parameter int ECW     = 12,
  parameter int DW      = 16,
  parameter int W_STALE = 2,
  parameter int W_ERASE = 3,
  localparam int BW     = $clog2(NBLK),
  localparam int PW     = $clog2(PPB),
  localparam int AW     = $clog2(NBLK * PPB),
  localparam int STW    = $clog2(PPB + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [ECW-1:0] erase_target,
  output logic           busy,
  output logic           done,
  output logic           found,
  output logic [BW-1:0]  victim,
  input  logic           meta_vld,
  input  logic           meta_op,
  input  logic [BW-1:0]  meta_blk,
  input  logic [PW-1:0]  meta_page,
  input  logic [BW-1:0]  mon_blk,
  output logic [PPB-1:0] mon_valid,
  output logic [STW-1:0] mon_stale,
  output logic [ECW-1:0] mon_erase,
  output logic [BW-1:0]  spare_blk,
  output logic           rd_vld,
  input  logic           rd_rdy,
  output logic [AW-1:0]  rd_addr,
  input  logic           rsp_vld,
  input  logic [DW-1:0]  rsp_data,
  output logic           wr_vld,
  input  logic           wr_rdy,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic           rec_vld,
  input  logic           rec_rdy,
  output logic [AW-1:0]  rec_old,
  output logic [AW-1:0]  rec_new,
  output logic           er_vld,
  input  logic           er_rdy,
  output logic [BW-1:0]  er_blk,
  input  logic           er_done
);
  localparam int SW = STW + ECW + $clog2(W_STALE + 1) + $clog2(W_ERASE + 1) + 1;

  logic                 host_we;
  logic                 rel_we, cmt_we;
  logic [BW-1:0]        rel_blk, cmt_blk, scan_blk;
  logic [PW-1:0]        rel_page;
  logic [PPB-1:0]       scan_valid;
  logic [STW-1:0]       scan_stale;
  logic [ECW-1:0]       scan_ecnt;
  logic                 elig;
  logic signed [SW-1:0] score;

  assign host_we = meta_vld && !busy && (meta_blk != spare_blk);

  gcv_meta_store #(.NBLK(NBLK), .PPB(PPB), .ECW(ECW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_inval(meta_op), .host_blk(meta_blk), .host_page(meta_page),
    .rel_we(rel_we), .rel_blk(rel_blk), .rel_page(rel_page),
    .cmt_we(cmt_we), .cmt_blk(cmt_blk),
    .scan_blk(scan_blk), .scan_valid(scan_valid), .scan_stale(scan_stale), .scan_ecnt(scan_ecnt),
    .mon_blk(mon_blk), .mon_valid(mon_valid), .mon_stale(mon_stale), .mon_ecnt(mon_erase)
  );

  gcv_scorer #(.NBLK(NBLK), .PPB(PPB), .ECW(ECW), .W_STALE(W_STALE), .W_ERASE(W_ERASE), .SW(SW)) score_i (
    .blk(scan_blk), .spare(spare_blk), .stale(scan_stale), .ecnt(scan_ecnt),
    .target(erase_target), .elig(elig), .score(score)
  );

  gcv_seq #(.NBLK(NBLK), .PPB(PPB), .DW(DW), .SW(SW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .found(found), .victim(victim), .spare(spare_blk),
    .scan_blk(scan_blk), .scan_valid(scan_valid), .elig(elig), .score(score),
    .rd_vld(rd_vld), .rd_rdy(rd_rdy), .rd_addr(rd_addr),
    .rsp_vld(rsp_vld), .rsp_data(rsp_data),
    .wr_vld(wr_vld), .wr_rdy(wr_rdy), .wr_addr(wr_addr), .wr_data(wr_data),
    .rec_vld(rec_vld), .rec_rdy(rec_rdy), .rec_old(rec_old), .rec_new(rec_new),
    .er_vld(er_vld), .er_rdy(er_rdy), .er_blk(er_blk), .er_done(er_done),
    .rel_we(rel_we), .rel_blk(rel_blk), .rel_page(rel_page),
    .cmt_we(cmt_we), .cmt_blk(cmt_blk)
  );
endmodule

// File: rtl/gcv_checker.sv
module gcv_checker #(
  parameter int AW = 6,
  parameter int BW = 3,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          rd_vld,
  input logic          rd_rdy,
  input logic [AW-1:0] rd_addr,
  input logic          wr_vld,
  input logic          wr_rdy,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          rec_vld,
  input logic          rec_rdy,
  input logic [AW-1:0] rec_old,
  input logic [AW-1:0] rec_new,
  input logic          er_vld,
  input logic          er_rdy,
  input logic [BW-1:0] er_blk
);
  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld && !rd_rdy |=> rd_vld && $stable(rd_addr));
  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld && !wr_rdy |=> wr_vld && $stable(wr_addr) && $stable(wr_data));
  // R7
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_vld && !rec_rdy |=> rec_vld && $stable(rec_old) && $stable(rec_new));
  // R7
  er_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    er_vld && !er_rdy |=> er_vld && $stable(er_blk));
  // R6
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_vld, wr_vld, rec_vld, er_vld}));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);
  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

bind gc_reclaim_engine gcv_checker #(.AW(AW), .BW(BW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rd_vld(rd_vld), .rd_rdy(rd_rdy), .rd_addr(rd_addr),
  .wr_vld(wr_vld), .wr_rdy(wr_rdy), .wr_addr(wr_addr), .wr_data(wr_data),
  .rec_vld(rec_vld), .rec_rdy(rec_rdy), .rec_old(rec_old), .rec_new(rec_new),
  .er_vld(er_vld), .er_rdy(er_rdy), .er_blk(er_blk)
);

// File: tb/gc_reclaim_engine_tb_top.sv
module gc_reclaim_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBLK = 8, PPB = 8, ECW = 12, DW = 16, WS = 2, WE = 3;
  localparam int BW = 3, PW = 3, AW = 6, STW = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [ECW-1:0] erase_target = 12'd100;
  logic busy, done, found;
  logic [BW-1:0] victim, spare_blk, er_blk;
  logic meta_vld = 1'b0, meta_op = 1'b0;
  logic [BW-1:0] meta_blk = '0, mon_blk = '0;
  logic [PW-1:0] meta_page = '0;
  logic [PPB-1:0] mon_valid;
  logic [STW-1:0] mon_stale;
  logic [ECW-1:0] mon_erase;
  logic rd_vld, wr_vld, rec_vld, er_vld;
  logic rd_rdy = 1'b0, wr_rdy = 1'b0, rec_rdy = 1'b0, er_rdy = 1'b0;
  logic rsp_vld = 1'b0, er_done = 1'b0;
  logic [DW-1:0] rsp_data = '0, wr_data;
  logic [AW-1:0] rd_addr, wr_addr, rec_old, rec_new;

  gc_reclaim_engine #(.NBLK(NBLK), .PPB(PPB), .ECW(ECW), .DW(DW), .W_STALE(WS), .W_ERASE(WE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .erase_target(erase_target),
    .busy(busy), .done(done), .found(found), .victim(victim),
    .meta_vld(meta_vld), .meta_op(meta_op), .meta_blk(meta_blk), .meta_page(meta_page),
    .mon_blk(mon_blk), .mon_valid(mon_valid), .mon_stale(mon_stale), .mon_erase(mon_erase),
    .spare_blk(spare_blk),
    .rd_vld(rd_vld), .rd_rdy(rd_rdy), .rd_addr(rd_addr), .rsp_vld(rsp_vld), .rsp_data(rsp_data),
    .wr_vld(wr_vld), .wr_rdy(wr_rdy), .wr_addr(wr_addr), .wr_data(wr_data),
    .rec_vld(rec_vld), .rec_rdy(rec_rdy), .rec_old(rec_old), .rec_new(rec_new),
    .er_vld(er_vld), .er_rdy(er_rdy), .er_blk(er_blk), .er_done(er_done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  // behavioural model
  bit m_valid [NBLK][PPB];
  bit m_pgm [NBLK][PPB];
  int m_stale [NBLK];
  int m_ecnt [NBLK];
  int m_spare = NBLK - 1;
  // expectations of the current run
  int exp_old[$], exp_new[$];
  bit exp_found = 0;
  int exp_victim = 0, first_valid = 0;
  bit running = 0, bp = 0, expect_done = 0, prev_done = 0;
  int k_run = 0, done_k = 0, first_rd_k = -1, dn_count = 0;
  int rd_i = 0, wr_i = 0, rec_i = 0, rsp_t = 0, er_t = 0, last_rd = 0, tick = 0;
  bit p_rd = 0, p_wr = 0, p_rec = 0, p_er = 0;
  int p_rd_a = 0, p_wr_a = 0, p_wr_d = 0, p_rec_o = 0, p_rec_n = 0, p_er_b = 0;

  function automatic int fdat(int a);
    return ((a * 37 + 5) ^ 16'hA5C3) & 16'hFFFF;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog expired: actual %0d expected below %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  function automatic void model_commit();
    for (int i = 0; i < exp_new.size(); i++) begin
      m_valid[m_spare][i] = 1;
      m_pgm[m_spare][i] = 1;
    end
    for (int p = 0; p < PPB; p++) begin
      m_valid[exp_victim][p] = 0;
      m_pgm[exp_victim][p] = 0;
    end
    m_stale[exp_victim] = 0;
    m_ecnt[exp_victim]++;
    m_spare = exp_victim;
  endfunction

  // flash stub, handshake checks and model comparison, all on the falling edge
  always @(negedge clk) begin
    tick++;
    rd_rdy  = bp ? tick[0] : 1'b1;
    wr_rdy  = bp ? tick[1] : 1'b1;
    rec_rdy = bp ? (tick % 3 == 0) : 1'b1;
    er_rdy  = bp ? tick[0] : 1'b1;
    #1;
    if (running) k_run++;
    if (p_rd) begin chk("R7", "read held", int'(rd_vld), 1); chk("R7", "read addr held", int'(rd_addr), p_rd_a); end
    if (p_wr) begin chk("R7", "write held", int'(wr_vld), 1); chk("R7", "write addr held", int'(wr_addr), p_wr_a);
                    chk("R7", "write data held", int'(wr_data), p_wr_d); end
    if (p_rec) begin chk("R7", "record held", int'(rec_vld), 1); chk("R7", "record old held", int'(rec_old), p_rec_o);
                     chk("R7", "record new held", int'(rec_new), p_rec_n); end
    if (p_er) begin chk("R7", "erase held", int'(er_vld), 1); chk("R7", "erase blk held", int'(er_blk), p_er_b); end
    p_rd = rd_vld && !rd_rdy;    p_rd_a = int'(rd_addr);
    p_wr = wr_vld && !wr_rdy;    p_wr_a = int'(wr_addr); p_wr_d = int'(wr_data);
    p_rec = rec_vld && !rec_rdy; p_rec_o = int'(rec_old); p_rec_n = int'(rec_new);
    p_er = er_vld && !er_rdy;    p_er_b = int'(er_blk);
    if (running && rd_vld && first_rd_k < 0) first_rd_k = k_run;
    if (rd_vld && rd_rdy) begin
      if (rd_i >= exp_old.size()) chk("R6", "unexpected read", int'(rd_addr), -1);
      else chk("R6", "read addr", int'(rd_addr), exp_old[rd_i]);
      last_rd = int'(rd_addr);
      rd_i++;
      rsp_t = 2;
    end
    rsp_vld = 1'b0;
    if (rsp_t > 0) begin
      rsp_t--;
      if (rsp_t == 0) begin rsp_vld = 1'b1; rsp_data = DW'(fdat(last_rd)); end
    end
    if (wr_vld && wr_rdy) begin
      if (wr_i >= exp_new.size()) chk("R6", "unexpected write", int'(wr_addr), -1);
      else begin
        chk("R6", "write addr", int'(wr_addr), exp_new[wr_i]);
        chk("R6", "write data", int'(wr_data), fdat(exp_old[wr_i]));
      end
      wr_i++;
    end
    if (rec_vld && rec_rdy) begin
      if (rec_i >= exp_old.size()) chk("R6", "unexpected record", int'(rec_old), -1);
      else begin
        chk("R6", "record old", int'(rec_old), exp_old[rec_i]);
        chk("R6", "record new", int'(rec_new), exp_new[rec_i]);
      end
      rec_i++;
    end
    if (er_vld && er_rdy) begin
      chk("R8", "erase issued with victim", int'(exp_found), 1);
      chk("R8", "erase block", int'(er_blk), exp_victim);
      chk("R8", "records before erase", rec_i, exp_old.size());
      er_t = 3;
    end
    if (expect_done) chk("R8", "done after erase-done", int'(done), 1);
    else if (done && exp_found) chk("R8", "done before erase-done", 1, 0);
    expect_done = 1'b0;
    er_done = 1'b0;
    if (er_t > 0) begin
      er_t--;
      if (er_t == 0) begin er_done = 1'b1; expect_done = 1'b1; end
    end
    if (prev_done) chk("R9", "done one cycle", int'(done), 0);
    prev_done = done;
    if (done) begin
      dn_count++;
      done_k = k_run;
      running = 0;
      chk("R4", "found flag", int'(found), int'(exp_found));
      if (exp_found) begin
        chk("R3", "victim index", int'(victim), exp_victim);
        model_commit();
      end
    end
    #1;
    if (!busy && rst_n) begin
      chk("R8", "spare block", int'(spare_blk), m_spare);
      for (int p = 0; p < PPB; p++) chk("R2", "valid bit", int'(mon_valid[p]), int'(m_valid[mon_blk][p]));
      chk("R2", "stale count", int'(mon_stale), m_stale[mon_blk]);
      chk("R8", "erase count", int'(mon_erase), m_ecnt[mon_blk]);
      mon_blk = mon_blk + 1'b1;
    end
  end

  task automatic meta(bit op, int blk, int page);
    @(negedge clk);
    meta_vld = 1'b1; meta_op = op; meta_blk = BW'(blk); meta_page = PW'(page);
    @(negedge clk);
    meta_vld = 1'b0;
    if (!running && blk != m_spare) begin
      if (!op) begin
        if (!m_pgm[blk][page]) begin m_pgm[blk][page] = 1; m_valid[blk][page] = 1; end
      end else if (m_valid[blk][page]) begin
        m_valid[blk][page] = 0;
        m_stale[blk]++;
      end
    end
  endtask

  task automatic run_gc(bit bp_on, bit poke, string tag);
    int best, w, pb, pp, cnt0;
    bp = bp_on;
    @(negedge clk);
    exp_found = 0; best = 0; exp_victim = 0;
    for (int b = 0; b < NBLK; b++) begin
      int s;
      s = m_stale[b] * WS - m_ecnt[b] * WE;
      if (b != m_spare && m_stale[b] > 0 && m_ecnt[b] < int'(erase_target) && (!exp_found || s > best)) begin
        exp_found = 1; best = s; exp_victim = b;
      end
    end
    exp_old.delete(); exp_new.delete();
    w = 0; first_valid = -1;
    if (exp_found)
      for (int p = 0; p < PPB; p++)
        if (m_valid[exp_victim][p]) begin
          if (first_valid < 0) first_valid = p;
          exp_old.push_back(exp_victim * PPB + p);
          exp_new.push_back(m_spare * PPB + w);
          w++;
        end
    rd_i = 0; wr_i = 0; rec_i = 0; first_rd_k = -1;
    k_run = -1; running = 1; cnt0 = dn_count;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #3;
    chk("R9", {"busy after start ", tag}, int'(busy), 1);
    if (poke) begin
      pb = -1; pp = 0;
      for (int b = 0; b < NBLK; b++)
        for (int p = 0; p < PPB; p++)
          if (pb < 0 && b != exp_victim && m_valid[b][p]) begin pb = b; pp = p; end
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (pb >= 0) meta(1'b1, pb, pp);
      meta(1'b0, exp_victim, 0);
    end
    for (int i = 0; i < 5000 && dn_count == cnt0; i++) @(negedge clk);
    chk("R9", {"one done ", tag}, dn_count - cnt0, 1);
    if (!exp_found) chk("R5", {"done cycle ", tag}, done_k, NBLK + 1);
    else chk("R5", {"first read cycle ", tag}, first_rd_k, NBLK + 2 + first_valid);
    chk("R6", {"records ", tag}, rec_i, exp_old.size());
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #3;
      chk("R9", {"no rerun ", tag}, int'(busy || done), 0);
    end
    bp = 0;
  endtask

  initial begin
    for (int b = 0; b < NBLK; b++) begin
      m_stale[b] = 0; m_ecnt[b] = 0;
      for (int p = 0; p < PPB; p++) begin m_valid[b][p] = 0; m_pgm[b][p] = 0; end
    end
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (NBLK + 2) @(negedge clk);
    chk("R1", "spare after reset", int'(spare_blk), NBLK - 1);
    // R4 R5: empty array, no victim
    run_gc(0, 0, "empty");
    // R2: populate blocks
    for (int p = 0; p < PPB; p++) meta(1'b0, 0, p);
    for (int p = 0; p < 6; p++) meta(1'b0, 1, p);
    for (int p = 0; p < 4; p++) meta(1'b0, 2, p);
    meta(1'b0, 7, 0);               // spare, ignored
    meta(1'b1, 0, 1); meta(1'b1, 0, 3);
    meta(1'b1, 1, 0);
    meta(1'b1, 2, 2); meta(1'b1, 2, 2); // second has no effect
    meta(1'b0, 2, 2);               // reprogram, no effect
    meta(1'b1, 3, 5);               // not valid, no effect
    repeat (NBLK + 2) @(negedge clk);
    // R3 R6 R7 R8 R9: victim 0 under back-pressure with ignored start and ops
    run_gc(1, 1, "first");
    repeat (NBLK + 2) @(negedge clk);
    // R3: tie between blocks 1 and 2, lower wins
    run_gc(0, 0, "tie");
    repeat (NBLK + 2) @(negedge clk);
    // R3: erase count weighs against the block with more stale pages
    for (int p = 0; p < 4; p++) meta(1'b0, 0, p);
    meta(1'b1, 0, 0); meta(1'b1, 0, 1);
    run_gc(1, 0, "weighted");
    repeat (NBLK + 2) @(negedge clk);
    // R4: erase target excludes worn blocks
    erase_target = 12'd1;
    run_gc(0, 0, "target none");
    meta(1'b1, 7, 0);
    run_gc(0, 0, "target pick");
    erase_target = 12'd100;
    repeat (NBLK + 2) @(negedge clk);
    summary();
    $finish;
  end
endmodule